// File: doc/BRIEF.md
# Command-Driven I/O Processor

This block takes data movement off the CPU. The CPU issues one short command that carries only an opcode and a device number. The processor then reads the transfer parameters from a command block in main memory. It moves words between the chosen device and memory, using memory cycles only when the memory arbiter grants them, and raises an interrupt when the work is done. The CPU reads the outcome from a status flag and clears the interrupt with a second opcode on the same port.

Each device owns a command block of four words at `BLK_BASE + 4*device`. Word offset 0 holds the operation, offset 1 the memory address of the data, offset 2 the word count, and offset 3 the request flags. The transfer parameters never pass through the command port. To start a transfer, software writes the device's block and then names the device.

Top module: `iop_core`

## Requirements
- R1: While reset is asserted, and after it, `irq`, `busy`, `err`, `mem_req`, `dev_rx_ready` and `dev_tx_valid` are all low.
- R2: A command with `cmd_opc` = 2'b01 (start) is taken, and `cmd_taken` is high in that same cycle, only when `busy` is low. Opcodes 2'b00 and 2'b11 do nothing. After a start, the processor reads the four block words at `BLK_BASE + 4*cmd_dev + 0..3`, in that order.
- R3: A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_gnt` is high. A read word is taken from `mem_rdata` in that cycle.
- R4: When the operation word is 1 (device to memory), the processor takes `count` words from the device, in order. It writes them to consecutive addresses that start at the address word, one write per word.
- R5: When the operation word is 2 (memory to device), the processor reads `count` consecutive words that start at the address word. It presents them on `dev_tx_data` in order, and each word is handed over when `dev_tx_valid` and `dev_tx_ready` are both high.
- R6: When bit 0 of the flags word is 1, the memory address stays the same for every word of the transfer. All other flag bits have no effect.
- R7: An operation word of 0, or a count (the low `CNT_W` bits of word 2) of zero, moves no data. It still completes with `irq` high and `err` low.
- R8: Any operation word other than 0, 1 or 2, compared over its full width, moves no data and completes with both `err` and `irq` high.
- R9: `irq` rises when the operation ends. It stays high until a command with `cmd_opc` = 2'b10 (acknowledge) arrives. That command clears `irq` and `err`, and has no effect while `irq` is low.
- R10: `busy` is high from the cycle after a start is taken until the cycle after the acknowledge. A start issued while busy is refused: `cmd_taken` stays low and the current operation is unaffected.
- R11: `dev_sel` carries the device number of the command that was taken. It does not change until the next start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | CPU command present |
| cmd_opc | input | 2 | 01 start, 10 acknowledge interrupt |
| cmd_dev | input | DEV_W | Target device for a start |
| cmd_taken | output | 1 | Start accepted this cycle |
| busy | output | 1 | Operation in progress or interrupt pending |
| irq | output | 1 | Completion interrupt |
| err | output | 1 | Completed operation had an unknown operation word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Access granted this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| dev_sel | output | DEV_W | Device being served |
| dev_rx_valid | input | 1 | Device has a word for memory |
| dev_rx_data | input | DW | Word from the device |
| dev_rx_ready | output | 1 | Processor takes the device word |
| dev_tx_valid | output | 1 | Word for the device present |
| dev_tx_data | output | DW | Word to the device |
| dev_tx_ready | input | 1 | Device accepts the word |

## Verification
The assertions assume that the memory side answers a request only with a grant in some later or the same cycle, and that `mem_rdata` is valid in the grant cycle. They also assume that the CPU never acknowledges before an interrupt is raised. The bench honours both conditions. Its memory model computes the grant from the request it sees in mid-cycle and serves reads combinationally from the current address. Its CPU tasks send an acknowledge only after `irq` has been seen high, plus one deliberate acknowledge while idle, which the design must ignore. Grants and device handshakes follow three stall patterns, so every wait state in the fetch and transfer loops is exercised.

// File: rtl/iop_pkg.sv
package iop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH   = 3'd1,
    ST_DECODE  = 3'd2,
    ST_DEV_IN  = 3'd3,
    ST_MEM_WR  = 3'd4,
    ST_MEM_RD  = 3'd5,
    ST_DEV_OUT = 3'd6,
    ST_DONE    = 3'd7
  } eng_state_t;

  localparam logic [1:0] HOST_START = 2'b01;
  localparam logic [1:0] HOST_ACK   = 2'b10;

  localparam int OPC_NOP        = 0;
  localparam int OPC_D2M        = 1;
  localparam int OPC_M2D        = 2;
  localparam int BLK_WORDS      = 4;
  localparam int FLAG_FIXED_BIT = 0;

endpackage

// File: rtl/iop_host_if.sv
module iop_host_if
  import iop_pkg::*;
#(
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_opc,
  input  logic [DEV_W-1:0] cmd_dev,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic             start_o,
  output logic [DEV_W-1:0] start_dev_o,
  output logic             cmd_taken,
  output logic             busy,
  output logic             irq,
  output logic             err
);

  logic busy_q, busy_d;
  logic irq_q, irq_d;
  logic err_q, err_d;
  logic start, ack;

  assign start = cmd_valid && (cmd_opc == HOST_START) && !busy_q;
  assign ack   = cmd_valid && (cmd_opc == HOST_ACK) && irq_q;

  always_comb begin
    busy_d = busy_q;
    irq_d  = irq_q;
    err_d  = err_q;
    if (start) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
    end
    if (eng_done) begin
      irq_d = 1'b1;
      err_d = eng_err;
    end
    if (ack) begin
      busy_d = 1'b0;
      irq_d  = 1'b0;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      irq_q  <= irq_d;
      err_q  <= err_d;
    end
  end

  assign start_o     = start;
  assign start_dev_o = cmd_dev;
  assign cmd_taken   = start;
  assign busy        = busy_q;
  assign irq         = irq_q;
  assign err         = err_q;

  // R9: a finished operation raises the interrupt
  a_r9_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> irq_q);
  // R9: the interrupt holds until acknowledged
  a_r9_irq_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !(cmd_valid && cmd_opc == HOST_ACK) |=> irq_q);
  // R10: busy persists while no acknowledge arrives
  a_r10_busy_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !(cmd_valid && cmd_opc == HOST_ACK) |=> busy_q);
  // R9: error status only exists alongside a pending interrupt
  a_r9_err_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> irq_q);

endmodule

// File: rtl/iop_engine.sv
module iop_engine
  import iop_pkg::*;
#(
  parameter int              AW       = 16,
  parameter int              DW       = 32,
  parameter int              DEV_W    = 2,
  parameter int              CNT_W    = 16,
  parameter logic [AW-1:0]   BLK_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEV_W-1:0] start_dev,
  output logic             done_o,
  output logic             err_o,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DEV_W-1:0] dev_sel,
  input  logic             dev_rx_valid,
  input  logic [DW-1:0]    dev_rx_data,
  output logic             dev_rx_ready,
  output logic             dev_tx_valid,
  output logic [DW-1:0]    dev_tx_data,
  input  logic             dev_tx_ready
);

  localparam int IDX_W = $clog2(BLK_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_WORDS - 1);

  eng_state_t       state_q, state_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DW-1:0]    op_q, op_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fixed_q, fixed_d;
  logic [DW-1:0]    data_q, data_d;
  logic             err_q, err_d;

  logic [AW-1:0] blk_addr, addr_step;
  logic          last_word, word_moved;

  assign blk_addr   = BLK_BASE + AW'({dev_q, idx_q});
  assign addr_step  = fixed_q ? addr_q : addr_q + AW'(1);
  assign last_word  = (cnt_q == CNT_W'(1));
  assign word_moved = ((state_q == ST_MEM_WR) && mem_gnt) ||
                      ((state_q == ST_DEV_OUT) && dev_tx_ready);

  always_comb begin
    state_d = state_q;
    dev_d   = dev_q;
    idx_d   = idx_q;
    op_d    = op_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    fixed_d = fixed_q;
    data_d  = data_q;
    err_d   = err_q;
    if (word_moved) begin
      addr_d = addr_step;
      cnt_d  = cnt_q - CNT_W'(1);
    end
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          dev_d   = start_dev;
          idx_d   = '0;
          err_d   = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_gnt) begin
          if (idx_q == IDX_W'(0))      op_d    = mem_rdata;
          else if (idx_q == IDX_W'(1)) addr_d  = mem_rdata[AW-1:0];
          else if (idx_q == IDX_W'(2)) cnt_d   = mem_rdata[CNT_W-1:0];
          else                         fixed_d = mem_rdata[FLAG_FIXED_BIT];
          idx_d = idx_q + IDX_W'(1);
          if (idx_q == IDX_LAST) state_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (op_q == DW'(OPC_D2M)) begin
          state_d = (cnt_q == '0) ? ST_DONE : ST_DEV_IN;
        end else if (op_q == DW'(OPC_M2D)) begin
          state_d = (cnt_q == '0) ? ST_DONE : ST_MEM_RD;
        end else if (op_q == DW'(OPC_NOP)) begin
          state_d = ST_DONE;
        end else begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DEV_IN: begin
        if (dev_rx_valid) begin
          data_d  = dev_rx_data;
          state_d = ST_MEM_WR;
        end
      end
      ST_MEM_WR: begin
        if (mem_gnt) state_d = last_word ? ST_DONE : ST_DEV_IN;
      end
      ST_MEM_RD: begin
        if (mem_gnt) begin
          data_d  = mem_rdata;
          state_d = ST_DEV_OUT;
        end
      end
      ST_DEV_OUT: begin
        if (dev_tx_ready) state_d = last_word ? ST_DONE : ST_MEM_RD;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dev_q   <= '0;
      idx_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      fixed_q <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dev_q   <= dev_d;
      idx_q   <= idx_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      fixed_q <= fixed_d;
      data_q  <= data_d;
      err_q   <= err_d;
    end
  end

  assign mem_req      = (state_q == ST_FETCH) || (state_q == ST_MEM_WR) ||
                        (state_q == ST_MEM_RD);
  assign mem_we       = (state_q == ST_MEM_WR);
  assign mem_addr     = (state_q == ST_FETCH) ? blk_addr : addr_q;
  assign mem_wdata    = data_q;
  assign dev_sel      = dev_q;
  assign dev_rx_ready = (state_q == ST_DEV_IN);
  assign dev_tx_valid = (state_q == ST_DEV_OUT);
  assign dev_tx_data  = data_q;
  assign done_o       = (state_q == ST_DONE);
  assign err_o        = err_q;

  // R3: an ungranted request is held unchanged
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) &&
                            $stable(mem_we) && $stable(mem_wdata));
  // R2: block words are fetched at consecutive addresses
  a_r2_fetch_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) && mem_gnt && (idx_q != IDX_LAST)
      |=> mem_addr == $past(mem_addr) + AW'(1));
  // R7: an empty count finishes straight after decode
  a_r7_empty_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE) && (cnt_q == '0) |=> state_q == ST_DONE);
  // R8: error completion only for an unknown operation word
  a_r8_err_only_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && err_o |-> (op_q != DW'(OPC_NOP)) && (op_q != DW'(OPC_D2M)) &&
                        (op_q != DW'(OPC_M2D)));
  // R11: the served device does not change mid-operation
  a_r11_dev_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) |-> $stable(dev_sel));
  // R6: a fixed-address transfer never moves its address
  a_r6_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_q && word_moved && !last_word |=> $stable(addr_q));

endmodule

// File: rtl/iop_core.sv
module iop_core
  import iop_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 32,
  parameter int            DEV_W    = 2,
  parameter int            CNT_W    = 16,
  parameter logic [AW-1:0] BLK_BASE = AW'(16'h0100)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_opc,
  input  logic [DEV_W-1:0] cmd_dev,
  output logic             cmd_taken,
  output logic             busy,
  output logic             irq,
  output logic             err,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DEV_W-1:0] dev_sel,
  input  logic             dev_rx_valid,
  input  logic [DW-1:0]    dev_rx_data,
  output logic             dev_rx_ready,
  output logic             dev_tx_valid,
  output logic [DW-1:0]    dev_tx_data,
  input  logic             dev_tx_ready
);

  logic [1:0]       rst_pipe_q;
  logic             rst_s_n;
  logic             start;
  logic [DEV_W-1:0] start_dev;
  logic             eng_done, eng_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  iop_host_if #(.DEV_W(DEV_W)) u_host (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .cmd_valid   (cmd_valid),
    .cmd_opc     (cmd_opc),
    .cmd_dev     (cmd_dev),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .start_o     (start),
    .start_dev_o (start_dev),
    .cmd_taken   (cmd_taken),
    .busy        (busy),
    .irq         (irq),
    .err         (err)
  );

  iop_engine #(
    .AW(AW), .DW(DW), .DEV_W(DEV_W), .CNT_W(CNT_W), .BLK_BASE(BLK_BASE)
  ) u_eng (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .start        (start),
    .start_dev    (start_dev),
    .done_o       (eng_done),
    .err_o        (eng_err),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_gnt      (mem_gnt),
    .mem_rdata    (mem_rdata),
    .dev_sel      (dev_sel),
    .dev_rx_valid (dev_rx_valid),
    .dev_rx_data  (dev_rx_data),
    .dev_rx_ready (dev_rx_ready),
    .dev_tx_valid (dev_tx_valid),
    .dev_tx_data  (dev_tx_data),
    .dev_tx_ready (dev_tx_ready)
  );

  // R1: nothing is requested or signalled while reset holds
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_s_n |-> !irq && !busy && !mem_req && !dev_rx_ready && !dev_tx_valid);
  // R10: a refused start leaves the taken strobe low
  a_r10_refuse_busy: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy && cmd_valid && cmd_opc == HOST_START |-> !cmd_taken);

endmodule

// File: tb/sim_iop_core.sv
module sim_iop_core;

  localparam int AW = 8, DW = 32, DEV_W = 2, CNT_W = 8;
  localparam logic [AW-1:0] BLK = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_opc = 2'b00;
  logic [DEV_W-1:0] cmd_dev = '0;
  logic cmd_taken, busy, irq, err, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_rx_data, dev_tx_data;
  logic mem_gnt = 1'b0, dev_rx_valid = 1'b0, dev_tx_ready = 1'b0;
  logic [DEV_W-1:0] dev_sel;
  logic dev_rx_ready, dev_tx_valid;

  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] sink [0:1023];
  int sink_cnt = 0, src_idx = 0;
  logic bw_en = 1'b0;
  logic [AW-1:0] bw_addr = '0;
  logic [DW-1:0] bw_data = '0;
  int mode = 0;
  logic [7:0] cyc = '0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  iop_core #(.AW(AW), .DW(DW), .DEV_W(DEV_W), .CNT_W(CNT_W), .BLK_BASE(BLK)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opc(cmd_opc),
    .cmd_dev(cmd_dev), .cmd_taken(cmd_taken), .busy(busy), .irq(irq), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .dev_sel(dev_sel),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid),
    .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready)
  );

  function automatic logic [DW-1:0] src_word(int i);
    return 32'hC000_0000 + 32'(i) * 32'd3 + 32'd7;
  endfunction

  function automatic logic [DW-1:0] pat(int tag, int i);
    return 32'h5A00_0000 + 32'(tag) * 32'd64 + 32'(i);
  endfunction

  function automatic logic slot(int m, logic [7:0] c);
    return (m == 0) || (m == 1 && c[0]) || (m == 2 && c[1:0] == 2'b00);
  endfunction

  assign mem_rdata   = mem[mem_addr];
  assign dev_rx_data = src_word(src_idx);

  always @(negedge clk) begin
    cyc          <= cyc + 8'd1;
    mem_gnt      <= mem_req && slot(mode, cyc);
    dev_rx_valid <= slot(mode, cyc + 8'd1);
    dev_tx_ready <= slot(mode, cyc + 8'd2);
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) mem[mem_addr] <= mem_wdata;
    else if (bw_en) mem[bw_addr] <= bw_data;
    if (dev_rx_valid && dev_rx_ready) src_idx <= src_idx + 1;
    if (dev_tx_valid && dev_tx_ready) begin
      sink[sink_cnt % 1024] <= dev_tx_data;
      sink_cnt <= sink_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic host(input logic [1:0] opc, input int dev);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opc = opc; cmd_dev = DEV_W'(dev);
    #1;
  endtask

  task automatic host_idle();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_opc = 2'b00;
  endtask

  task automatic run_op(input int dev, input logic [DW-1:0] op, input int cnt,
                        input int fixed, input int m, input int tag);
    logic [AW-1:0] base;
    int s0, k0, hit;
    logic known, moves;
    base  = AW'(8'h40 + dev * 16);
    known = (op == 0) || (op == 1) || (op == 2);
    moves = (op == 1 || op == 2) && cnt > 0;
    mode  = m;
    for (int i = 0; i < 16; i++) bwrite(base + AW'(i), pat(tag, i));
    bwrite(BLK + AW'(dev * 4),     op);
    bwrite(BLK + AW'(dev * 4 + 1), {24'h00A5_00, base});
    bwrite(BLK + AW'(dev * 4 + 2), 32'hFF00_0000 | 32'(cnt));
    bwrite(BLK + AW'(dev * 4 + 3), 32'h8000_0006 | 32'(fixed));
    s0 = src_idx; k0 = sink_cnt;
    host(2'b01, dev);
    chk(cmd_taken == 1'b1, "R2 start taken when idle", 32'(cmd_taken), 1);
    host_idle();
    chk(busy == 1'b1, "R10 busy after start", 32'(busy), 1);
    hit = 0;
    for (int i = 0; i < 600; i++) begin
      if (irq) begin hit = 1; break; end
      @(negedge clk);
    end
    chk(hit == 1, "R9 interrupt raised", 32'(hit), 1);
    chk(err == !known, "R8 error status", 32'(err), 32'(!known));
    chk(dev_sel == DEV_W'(dev), "R11 device select", 32'(dev_sel), 32'(dev));
    if (op == 1 && cnt > 0) begin
      chk(src_idx - s0 == cnt, "R4 words taken from device", 32'(src_idx - s0), 32'(cnt));
      for (int i = 0; i < 16; i++) begin
        logic [DW-1:0] e;
        if (fixed != 0) e = (i == 0) ? src_word(s0 + cnt - 1) : pat(tag, i);
        else            e = (i < cnt) ? src_word(s0 + i) : pat(tag, i);
        chk(mem[base + AW'(i)] == e, fixed != 0 ? "R6 fixed address write" : "R4 memory write",
            mem[base + AW'(i)], e);
      end
    end else begin
      chk(src_idx == s0, "R7 no device words taken", 32'(src_idx - s0), 0);
      for (int i = 0; i < 16; i++)
        chk(mem[base + AW'(i)] == pat(tag, i), moves ? "R5 memory untouched" : "R7 memory untouched",
            mem[base + AW'(i)], pat(tag, i));
    end
    if (op == 2 && cnt > 0) begin
      chk(sink_cnt - k0 == cnt, "R5 words delivered", 32'(sink_cnt - k0), 32'(cnt));
      for (int i = 0; i < cnt; i++) begin
        logic [DW-1:0] e;
        e = pat(tag, fixed != 0 ? 0 : i);
        chk(sink[(k0 + i) % 1024] == e, fixed != 0 ? "R6 fixed address read" : "R5 device data",
            sink[(k0 + i) % 1024], e);
      end
    end else begin
      chk(sink_cnt == k0, "R7 no device words sent", 32'(sink_cnt - k0), 0);
    end
    host(2'b01, (dev + 1) % 4);
    chk(cmd_taken == 1'b0, "R10 start refused while busy", 32'(cmd_taken), 0);
    host_idle();
    chk(irq && busy && dev_sel == DEV_W'(dev), "R10 refused start no effect",
        {30'd0, irq, busy}, 32'h3);
    host(2'b10, 0);
    host_idle();
    chk(!irq && !busy && !err, "R9 acknowledge clears", {29'd0, irq, busy, err}, 0);
  endtask

  initial begin
    int tag;
    tag = 0;
    repeat (3) @(negedge clk);
    chk(!irq && !busy && !err && !mem_req && !dev_rx_ready && !dev_tx_valid,
        "R1 reset state", {26'd0, irq, busy, err, mem_req, dev_rx_ready, dev_tx_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!irq && !busy && !mem_req, "R1 after release", {29'd0, irq, busy, mem_req}, 0);
    host(2'b00, 1);
    chk(cmd_taken == 1'b0, "R2 opcode 00 ignored", 32'(cmd_taken), 0);
    host(2'b11, 2);
    chk(cmd_taken == 1'b0, "R2 opcode 11 ignored", 32'(cmd_taken), 0);
    host(2'b10, 0);
    host_idle();
    chk(!busy && !irq && !mem_req, "R9 idle acknowledge ignored", {29'd0, busy, irq, mem_req}, 0);
    for (int d = 0; d < 4; d++)
      for (int o = 1; o <= 2; o++)
        for (int c = 0; c <= 4; c++)
          for (int f = 0; f < 2; f++) begin
            tag++;
            run_op(d, 32'(o), c, f, (d + c + f) % 3, tag);
          end
    for (int d = 0; d < 4; d++) begin
      tag++; run_op(d, 32'd0, 3, 0, d % 3, tag);
      tag++; run_op(d, 32'd3, 3, 0, 1, tag);
      tag++; run_op(d, 32'h0000_0101, 2, 1, 2, tag);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule